// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block sits beside the instruction decoder of an 8-bit processor whose stack lives in page one of memory. Every cycle in which the ready qualifier is high and the sequencer is idle is an instruction boundary. In that cycle the opcode fetch runs, marked by the fetch strobe, and the sequencer chooses one of three things. It can start a reset entry, start a non-maskable or maskable interrupt entry, or start a software break. If none of these applies, it hands the fetched opcode to the execution unit. That unit is outside this block and holds the ready line low while it works.

An entry drives the bus cycle by cycle. Three stack cycles store the return address and the status byte. A reset runs the same three cycles with the bus left in read mode, so nothing is written. Two reads then fetch the new program counter from the top page of memory. A final cycle presents the updated program counter, stack pointer and status for the register file to load. A software break first reads and skips the padding byte that follows its opcode.

Top module: `cpu_entry_seq`

## Requirements
- R1: At a boundary the choice is made in this priority order: reset line low, then a latched non-maskable request, then the maskable line low with status bit 2 (interrupt disable) clear, then `brk_req` high. A software break is therefore taken only when no hardware request is pending.
- R2: While status bit 2 is set, a low `irq_n` line starts no entry. The boundary then hands off to execution, as in R12.
- R3: While `rdy` is low, the state, the bus address and the `pc_out`/`s_out`/`p_out` values hold, and no boundary decision is made.
- R4: In a boundary cycle `sync` is 1, `addr` equals `pc_in` and `rw` is 1 (read).
- R5: Each stack cycle addresses `{0x01, S}` with the current S, and S is decremented once per stack cycle.
- R6: A non-reset entry writes (`rw` = 0) the PC high byte, then the PC low byte, then the status. The stored status has bit 4 (break) set only for a software break and cleared for a hardware source. All other status bits are stored unchanged.
- R7: A reset entry runs three stack cycles with `rw` = 1 and `wdata` = 0, and still leaves S three lower.
- R8: The new PC is read low byte first from `0xFF00 + offset`, then high byte from the next address. The offset is 0xFC for reset, 0xFA for the non-maskable request, and 0xFE for the maskable request and the break.
- R9: The cycle after the high vector read, `regs_load` is 1 for exactly one cycle. In that cycle `pc_out` holds the vector, `s_out` holds the entry S minus 3, and `p_out` holds the entry status with bit 2 set.
- R10: The non-maskable input responds to a falling edge, which is latched. A line held low after its service produces no second entry.
- R11: A software break reads the padding byte at `pc_in + 1` and stores `pc_in + 2` as the return address. A hardware interrupt stores `pc_in`.
- R12: A boundary that starts no entry pulses `run_op` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| res_n | input | 1 | Processor reset request, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low level |
| rdy | input | 1 | Ready qualifier; the sequencer advances only when high |
| brk_req | input | 1 | Fetched opcode is the software break |
| pc_in | input | 16 | Current program counter |
| s_in | input | 8 | Current stack pointer |
| p_in | input | 8 | Current status register |
| rdata | input | 8 | Bus read data |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Bus write data |
| rw | output | 1 | 1 = read, 0 = write |
| sync | output | 1 | Opcode fetch / boundary cycle |
| run_op | output | 1 | Fetched opcode handed to execution |
| regs_load | output | 1 | Updated PC, S and P are valid |
| pc_out | output | 16 | Updated program counter |
| s_out | output | 8 | Updated stack pointer |
| p_out | output | 8 | Updated status register |

## Verification
The hardest situation to reach is the non-maskable line still held low at the next boundary after its own service. At that point the edge latch must already be clear even though the line level still asks for service. The stimulus lowers the line in a stalled cycle before one entry, keeps it low through the whole sequence, and then presents a quiet boundary that must hand off to execution. The stimulus also stalls the sequencer in the middle of a stack cycle and presents all requests together. Finally, it sweeps stack pointers across the page wrap and program counters across the top of memory, so that the decrement and the break's plus-two arithmetic wrap.

// File: rtl/entry_seq_pkg.sv
package entry_seq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_PAD,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_PUSH_P,
    ST_VEC_L,
    ST_VEC_H,
    ST_LOAD
  } seq_state_t;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RESET,
    SRC_NMI,
    SRC_IRQ,
    SRC_BRK
  } entry_src_t;

endpackage

// File: rtl/entry_nmi_latch.sv
module entry_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic take,
  output logic pending
);

  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall    = prev_q & ~nmi_n;
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      pend_q <= (pend_q & ~take) | fall;
    end
  end

endmodule

// File: rtl/entry_arbiter.sv
module entry_arbiter
  import entry_seq_pkg::*;
(
  input  logic       res_n,
  input  logic       nmi_pend,
  input  logic       irq_n,
  input  logic       irq_masked,
  input  logic       brk_req,
  output entry_src_t choice
);

  always_comb begin
    if (!res_n)                     choice = SRC_RESET;
    else if (nmi_pend)              choice = SRC_NMI;
    else if (!irq_n && !irq_masked) choice = SRC_IRQ;
    else if (brk_req)               choice = SRC_BRK;
    else                            choice = SRC_NONE;
  end

endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import entry_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int I_BIT  = 2,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy,
  input  entry_src_t        choice,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] s_in,
  input  logic [DATA_W-1:0] p_in,
  input  logic [DATA_W-1:0] rdata,
  output seq_state_t        state,
  output entry_src_t        src,
  output logic [ADDR_W-1:0] pc_w,
  output logic [DATA_W-1:0] s_w,
  output logic [DATA_W-1:0] p_w,
  output logic              run_q,
  output logic              take_nmi
);

  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
  localparam logic [DATA_W-1:0] S_ONE  = DATA_W'(1);

  seq_state_t state_q;
  entry_src_t src_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] s_q;
  logic [DATA_W-1:0] p_q;
  logic run_r;
  logic at_boundary;

  assign at_boundary = rdy && (state_q == ST_FETCH);
  assign take_nmi    = at_boundary && (choice == SRC_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      src_q   <= SRC_NONE;
      pc_q    <= '0;
      s_q     <= '0;
      p_q     <= '0;
      run_r   <= 1'b0;
    end else begin
      run_r <= 1'b0;
      if (rdy) begin
        unique case (state_q)
          ST_FETCH: begin
            if (choice == SRC_NONE) begin
              run_r <= 1'b1;
            end else begin
              src_q <= choice;
              s_q   <= s_in;
              p_q   <= p_in;
              if (choice == SRC_BRK) begin
                pc_q    <= pc_in + PC_ONE;
                state_q <= ST_PAD;
              end else begin
                pc_q    <= pc_in;
                state_q <= ST_PUSH_H;
              end
            end
          end
          ST_PAD: begin
            pc_q    <= pc_q + PC_ONE;
            state_q <= ST_PUSH_H;
          end
          ST_PUSH_H: begin
            s_q     <= s_q - S_ONE;
            state_q <= ST_PUSH_L;
          end
          ST_PUSH_L: begin
            s_q     <= s_q - S_ONE;
            state_q <= ST_PUSH_P;
          end
          ST_PUSH_P: begin
            s_q        <= s_q - S_ONE;
            p_q[I_BIT] <= 1'b1;
            state_q    <= ST_VEC_L;
          end
          ST_VEC_L: begin
            pc_q[DATA_W-1:0] <= rdata;
            state_q          <= ST_VEC_H;
          end
          ST_VEC_H: begin
            pc_q[ADDR_W-1:DATA_W] <= rdata;
            state_q               <= ST_LOAD;
          end
          ST_LOAD: begin
            state_q <= ST_FETCH;
          end
          default: state_q <= ST_FETCH;
        endcase
      end
    end
  end

  assign state = state_q;
  assign src   = src_q;
  assign pc_w  = pc_q;
  assign s_w   = s_q;
  assign p_w   = p_q;
  assign run_q = run_r;

endmodule

// File: rtl/entry_bus_mux.sv
module entry_bus_mux
  import entry_seq_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] VEC_PAGE   = 8'hFF,
  parameter logic [DATA_W-1:0] VEC_RESET  = 8'hFC,
  parameter logic [DATA_W-1:0] VEC_NMI    = 8'hFA,
  parameter logic [DATA_W-1:0] VEC_IRQ    = 8'hFE,
  parameter int               B_BIT      = 4,
  localparam int              ADDR_W     = 2 * DATA_W
) (
  input  seq_state_t        state,
  input  entry_src_t        src,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] pc_w,
  input  logic [DATA_W-1:0] s_w,
  input  logic [DATA_W-1:0] p_w,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rw
);

  logic [DATA_W-1:0] vec_off;
  logic [DATA_W-1:0] stacked_p;
  logic              writes;

  always_comb begin
    unique case (src)
      SRC_RESET: vec_off = VEC_RESET;
      SRC_NMI:   vec_off = VEC_NMI;
      default:   vec_off = VEC_IRQ;
    endcase
  end

  always_comb begin
    stacked_p        = p_w;
    stacked_p[B_BIT] = (src == SRC_BRK);
  end

  assign writes = (src != SRC_RESET);

  always_comb begin
    addr  = pc_w;
    wdata = '0;
    rw    = 1'b1;
    unique case (state)
      ST_FETCH: addr = pc_in;
      ST_PAD:   addr = pc_w;
      ST_PUSH_H: begin
        addr = {STACK_PAGE, s_w};
        if (writes) begin
          rw    = 1'b0;
          wdata = pc_w[ADDR_W-1:DATA_W];
        end
      end
      ST_PUSH_L: begin
        addr = {STACK_PAGE, s_w};
        if (writes) begin
          rw    = 1'b0;
          wdata = pc_w[DATA_W-1:0];
        end
      end
      ST_PUSH_P: begin
        addr = {STACK_PAGE, s_w};
        if (writes) begin
          rw    = 1'b0;
          wdata = stacked_p;
        end
      end
      ST_VEC_L: addr = {VEC_PAGE, vec_off};
      ST_VEC_H: addr = {VEC_PAGE, vec_off | DATA_W'(1)};
      ST_LOAD:  addr = pc_w;
      default:  addr = pc_w;
    endcase
  end

endmodule

// File: rtl/cpu_entry_seq.sv
module cpu_entry_seq
  import entry_seq_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] VEC_PAGE   = 8'hFF,
  parameter logic [DATA_W-1:0] VEC_RESET  = 8'hFC,
  parameter logic [DATA_W-1:0] VEC_NMI    = 8'hFA,
  parameter logic [DATA_W-1:0] VEC_IRQ    = 8'hFE,
  parameter int               I_BIT      = 2,
  parameter int               B_BIT      = 4,
  localparam int              ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_n,
  input  logic              nmi_n,
  input  logic              irq_n,
  input  logic              rdy,
  input  logic              brk_req,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] s_in,
  input  logic [DATA_W-1:0] p_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rw,
  output logic              sync,
  output logic              run_op,
  output logic              regs_load,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] s_out,
  output logic [DATA_W-1:0] p_out
);

  seq_state_t        state_q;
  entry_src_t        src_q;
  entry_src_t        choice;
  logic              nmi_pend;
  logic              take_nmi;
  logic [ADDR_W-1:0] pc_w;
  logic [DATA_W-1:0] s_w;
  logic [DATA_W-1:0] p_w;
  logic              run_q;

  entry_nmi_latch u_nmi (
    .clk     (clk),
    .rst     (rst),
    .nmi_n   (nmi_n),
    .take    (take_nmi),
    .pending (nmi_pend)
  );

  entry_arbiter u_arb (
    .res_n      (res_n),
    .nmi_pend   (nmi_pend),
    .irq_n      (irq_n),
    .irq_masked (p_in[I_BIT]),
    .brk_req    (brk_req),
    .choice     (choice)
  );

  entry_fsm #(
    .DATA_W (DATA_W),
    .I_BIT  (I_BIT)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .rdy      (rdy),
    .choice   (choice),
    .pc_in    (pc_in),
    .s_in     (s_in),
    .p_in     (p_in),
    .rdata    (rdata),
    .state    (state_q),
    .src      (src_q),
    .pc_w     (pc_w),
    .s_w      (s_w),
    .p_w      (p_w),
    .run_q    (run_q),
    .take_nmi (take_nmi)
  );

  entry_bus_mux #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .VEC_PAGE   (VEC_PAGE),
    .VEC_RESET  (VEC_RESET),
    .VEC_NMI    (VEC_NMI),
    .VEC_IRQ    (VEC_IRQ),
    .B_BIT      (B_BIT)
  ) u_bus (
    .state (state_q),
    .src   (src_q),
    .pc_in (pc_in),
    .pc_w  (pc_w),
    .s_w   (s_w),
    .p_w   (p_w),
    .addr  (addr),
    .wdata (wdata),
    .rw    (rw)
  );

  assign sync      = (state_q == ST_FETCH);
  assign regs_load = (state_q == ST_LOAD);
  assign run_op    = run_q;
  assign pc_out    = pc_w;
  assign s_out     = s_w;
  assign p_out     = p_w;

endmodule

// File: rtl/entry_seq_chk.sv
module entry_seq_chk
  import entry_seq_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] VEC_PAGE   = 8'hFF,
  parameter int               I_BIT      = 2,
  parameter int               B_BIT      = 4,
  localparam int              ADDR_W     = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              rdy,
  input seq_state_t        state,
  input entry_src_t        src,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rw,
  input logic              sync,
  input logic              run_op,
  input logic              regs_load,
  input logic [ADDR_W-1:0] pc_out,
  input logic [DATA_W-1:0] s_out,
  input logic [DATA_W-1:0] p_out
);

  logic in_push;
  assign in_push = (state == ST_PUSH_H) || (state == ST_PUSH_L) || (state == ST_PUSH_P);

  // R5
  write_page_chk: assert property (@(posedge clk) disable iff (rst)
    !rw |-> addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R5
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && in_push) |=> s_out == $past(s_out) - DATA_W'(1));

  // R7
  reset_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (in_push && src == SRC_RESET) |-> rw);

  // R6
  brk_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PUSH_P && !rw) |-> wdata[B_BIT] == (src == SRC_BRK));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> ($stable(s_out) && $stable(pc_out) && $stable(p_out) && $stable(state)));

  // R4
  fetch_read_chk: assert property (@(posedge clk) disable iff (rst)
    sync |-> rw);

  // R8
  vec_page_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VEC_L || state == ST_VEC_H) |-> (rw && addr[ADDR_W-1:DATA_W] == VEC_PAGE));

  // R9
  load_iflag_chk: assert property (@(posedge clk) disable iff (rst)
    regs_load |-> p_out[I_BIT]);

  // R9
  load_once_chk: assert property (@(posedge clk) disable iff (rst)
    regs_load |=> !regs_load);

  // R12
  run_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({run_op, regs_load}));

endmodule

bind cpu_entry_seq entry_seq_chk #(
  .DATA_W     (DATA_W),
  .STACK_PAGE (STACK_PAGE),
  .VEC_PAGE   (VEC_PAGE),
  .I_BIT      (I_BIT),
  .B_BIT      (B_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdy       (rdy),
  .state     (state_q),
  .src       (src_q),
  .addr      (addr),
  .wdata     (wdata),
  .rw        (rw),
  .sync      (sync),
  .run_op    (run_op),
  .regs_load (regs_load),
  .pc_out    (pc_out),
  .s_out     (s_out),
  .p_out     (p_out)
);

// File: tb/cpu_entry_seq_test.sv
`timescale 1ns/1ps
module cpu_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1, rdy = 1'b0, brk_req = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  s_in = '0, p_in = '0, rdata = '0;
  logic [15:0] addr, pc_out;
  logic [7:0]  wdata, s_out, p_out;
  logic        rw, sync, run_op, regs_load;

  int n_tests = 0;
  int n_fail  = 0;
  bit nmi_hold = 1'b0;

  always #10 clk = ~clk;

  cpu_entry_seq uut (
    .clk(clk), .rst(rst), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n), .rdy(rdy),
    .brk_req(brk_req), .pc_in(pc_in), .s_in(s_in), .p_in(p_in), .rdata(rdata),
    .addr(addr), .wdata(wdata), .rw(rw), .sync(sync), .run_op(run_op),
    .regs_load(regs_load), .pc_out(pc_out), .s_out(s_out), .p_out(p_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit r);
    @(negedge clk);
    rdy = r;
  endtask

  // kind: 0 reset, 1 nmi, 2 irq, 3 brk, 4 none
  task automatic do_entry(input bit a_res, input bit a_nmi, input bit a_irq, input bit a_brk,
                          input logic [15:0] pc, input logic [7:0] s, input logic [7:0] p,
                          input bit stall, input string none_tag);
    int kind;
    logic [15:0] epc;
    logic [7:0]  off, lo, hi;
    logic [7:0]  exp_b [3];
    kind = a_res ? 0 : (a_nmi ? 1 : ((a_irq && !p[2]) ? 2 : (a_brk ? 3 : 4)));
    epc  = (kind == 3) ? pc + 16'd2 : pc;
    off  = (kind == 0) ? 8'hFC : ((kind == 1) ? 8'hFA : 8'hFE);
    lo   = pc[7:0] ^ 8'h3C;
    hi   = s ^ 8'hC3;
    exp_b[0] = epc[15:8];
    exp_b[1] = epc[7:0];
    exp_b[2] = (kind == 3) ? (p | 8'h10) : (p & 8'hEF);
    // prep cycle, stalled
    cyc(1'b0);
    res_n = !a_res; nmi_n = !(a_nmi || nmi_hold); irq_n = !a_irq;
    pc_in = pc; s_in = s; p_in = p; brk_req = 1'b0;
    // boundary
    cyc(1'b1);
    brk_req = a_brk;
    #5;
    chk(sync == 1'b1, "R4 sync", sync, 1);
    chk(addr == pc, "R4 addr", addr, pc);
    chk(rw == 1'b1, "R4 rw", rw, 1);
    chk(run_op == 1'b0, "R3 no decision while stalled", run_op, 0);
    if (kind == 4) begin
      cyc(1'b0);
      brk_req = 1'b0; res_n = 1'b1; irq_n = 1'b1;
      #5;
      chk(run_op == 1'b1, none_tag, run_op, 1);
      chk(regs_load == 1'b0, none_tag, regs_load, 0);
      cyc(1'b0);
      #5;
      chk(run_op == 1'b0 && sync == 1'b1, "R12 single pulse", {run_op, sync}, 2'b01);
      return;
    end
    if (kind == 3) begin
      cyc(1'b1);
      brk_req = 1'b0;
      #5;
      chk(addr == pc + 16'd1 && rw == 1'b1, "R11 pad read", addr, pc + 16'd1);
    end
    for (int i = 0; i < 3; i++) begin
      int reps;
      reps = (stall && i == 1) ? 3 : 1;
      for (int r = 0; r < reps; r++) begin
        cyc(r == reps - 1);
        brk_req = 1'b0; res_n = 1'b1; irq_n = 1'b1;
        #5;
        chk(addr == {8'h01, s - 8'(i)}, (r > 0) ? "R3 stall hold addr" : "R5 stack addr",
            addr, {8'h01, s - 8'(i)});
        chk(s_out == s - 8'(i), (r > 0) ? "R3 stall hold S" : "R5 S count", s_out, s - 8'(i));
        if (kind == 0) begin
          chk(rw == 1'b1 && wdata == 8'h00, "R7 reset no write", {rw, wdata}, 9'h100);
        end else begin
          chk(rw == 1'b0, "R6 write", rw, 0);
          chk(wdata == exp_b[i], (i == 2) ? "R6 pushed status" : "R11 pushed PC", wdata, exp_b[i]);
        end
      end
    end
    cyc(1'b1);
    rdata = lo;
    #5;
    chk(addr == {8'hFF, off} && rw == 1'b1, "R8 vector low addr", addr, {8'hFF, off});
    cyc(1'b1);
    rdata = hi;
    #5;
    chk(addr == {8'hFF, off + 8'd1}, "R8 vector high addr", addr, {8'hFF, off + 8'd1});
    cyc(1'b1);
    nmi_n = !nmi_hold;
    #5;
    chk(regs_load == 1'b1, "R9 load strobe", regs_load, 1);
    chk(pc_out == {hi, lo}, "R8 new PC", pc_out, {hi, lo});
    chk(s_out == s - 8'd3, (kind == 0) ? "R7 reset S" : "R9 S out", s_out, s - 8'd3);
    chk(p_out == (p | 8'h04), "R9 P out", p_out, p | 8'h04);
    cyc(1'b0);
    #5;
    chk(regs_load == 1'b0 && sync == 1'b1, "R9 one cycle load", {regs_load, sync}, 2'b01);
  endtask

  function automatic logic [15:0] pc_pick(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h1234;
      2: return 16'hFFFE;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [7:0] s_pick(int i);
    case (i)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h02;
      3: return 8'h80;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] p_pick(int i);
    case (i)
      0: return 8'h00;
      1: return 8'h10;
      2: return 8'h3B;
      3: return 8'hC3;
      4: return 8'hFF;
      default: return 8'h04;
    endcase
  endfunction

  initial begin
    #3_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    chk(sync == 1'b1 && rw == 1'b1, "R4 reset state", {sync, rw}, 2'b11);
    chk(run_op == 1'b0 && regs_load == 1'b0, "R12 reset state", {run_op, regs_load}, 0);
    chk(pc_out == 16'h0 && s_out == 8'h0, "R9 reset state", {pc_out, s_out}, 0);

    // R1 priority
    do_entry(1, 1, 1, 1, 16'h4000, 8'hFD, 8'h00, 0, "R1");
    do_entry(0, 1, 1, 1, 16'h4100, 8'hFD, 8'h00, 0, "R1");
    do_entry(0, 0, 1, 1, 16'h4200, 8'hFD, 8'h00, 0, "R1");
    do_entry(0, 0, 1, 1, 16'h4300, 8'hFD, 8'h04, 0, "R1");
    // R2 masked
    do_entry(0, 0, 1, 0, 16'h4400, 8'hFD, 8'h04, 0, "R2 masked irq runs opcode");
    // R12 quiet boundary
    do_entry(0, 0, 0, 0, 16'h4500, 8'hFD, 8'h00, 0, "R12 run handoff");
    // R3 stalls inside the stack cycles
    do_entry(0, 0, 0, 1, 16'h4600, 8'h10, 8'h21, 1, "R3");
    do_entry(1, 0, 0, 0, 16'h4700, 8'h10, 8'h21, 1, "R3");
    // R10 held low
    nmi_hold = 1'b1;
    do_entry(0, 1, 0, 0, 16'h4800, 8'h50, 8'h00, 0, "R10");
    do_entry(0, 0, 0, 0, 16'h4900, 8'h50, 8'h00, 0, "R10 held line served once");
    nmi_hold = 1'b0;
    cyc(1'b0);
    nmi_n = 1'b1;
    do_entry(0, 1, 0, 0, 16'h4A00, 8'h50, 8'h00, 0, "R10 new edge");

    // sweep
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 5; b++)
          for (int c = 0; c < 6; c++) begin
            logic [7:0] pv;
            pv = p_pick(c);
            if (!(k == 2 && pv[2]))
              do_entry(k == 0, k == 1, k == 2, k == 3, pc_pick(a), s_pick(b), pv,
                       (a == b), "R1 sweep");
          end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule